// File: doc/BRIEF.md
# Eight-Channel Low-Side Driver Fault Guard

This block keeps the digital protection and diagnostic state for eight low-side switches. Each channel receives its commanded on/off bit from the serial write path, together with three sensed flags: overcurrent, over-temperature and a comparator result that says whether the output voltage lies above the diagnostic threshold. A single `limit_mode` pin chooses between two protection policies. When it is low, a sustained overcurrent latches the channel off. When it is high, overcurrent is tolerated as current limiting, and only over-temperature trips the channel. Each channel drives a gate enable and a status bit.

A shared blanking timer is reloaded with `BLANK_CYCLES` on every `commit` strobe, which marks a completed serial write. While the timer runs, overcurrent cannot latch a channel off, so switch-on surges pass. Each channel runs a four-state machine. The states are IDLE (off), BLANK (on, timer still running), RUN (on, protection armed) and TRIP (overload latch set). Its transitions are named as follows.

- commit: from any state, to BLANK if the new command bit is 1, otherwise to IDLE.
- switch-on: IDLE to BLANK when the command bit is 1 without a strobe.
- release: BLANK or RUN to IDLE when the command bit is 0.
- arm: BLANK to RUN when the timer has expired and no latching overcurrent is present.
- late-trip: BLANK to TRIP when the timer expires while a latching overcurrent is present.
- thermal-trip: BLANK or RUN to TRIP on over-temperature.
- short-trip: RUN to TRIP on overcurrent while `limit_mode` is low.

TRIP is left only by commit. The status bit repeats the comparator result. A tripped channel always reports 1, because its drain floats high.

Top module: `lsd_guard`

## Requirements
- R1: While `rst_n` is low, every bit of `gate_en` is 0.
- R2: With no fault flags, the cycle after a `commit` strobe, `gate_en` equals the `cmd_on` value sampled with the strobe. Bit i set means channel i is switched on.
- R3: With `limit_mode` low and overcurrent on channel i held from the strobe onward, `gate_en[i]` stays high for exactly `BLANK_CYCLES`+1 clock cycles after the strobe edge and then falls. The other channels keep their commanded value.
- R4: An overcurrent that disappears before the blanking timer expires has no effect on `gate_en`.
- R5: After blanking has expired, with `limit_mode` low, overcurrent on a conducting channel clears its `gate_en` bit at the next clock edge.
- R6: With `limit_mode` high, overcurrent never clears `gate_en`, however long it lasts.
- R7: Over-temperature on a conducting channel clears its `gate_en` bit at the next clock edge, in either mode and also during blanking.
- R8: A tripped channel keeps `gate_en` at 0 and `status` at 1 until the next strobe, even after the fault flags return to 0.
- R9: A strobe clears every latch. A channel given command bit 0 stays off. A strobe in the same cycle as a trip condition wins, so the channel conducts in the following cycle and trips one edge later if the condition persists.
- R10: For every channel that is not tripped, `status[i]` equals `vout_high[i]` in the same cycle. Here 1 means the output is above the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; all channels off |
| commit | input | 1 | One-cycle strobe marking a completed serial write |
| cmd_on | input | CHANNELS | Commanded state per channel, 1 = on |
| limit_mode | input | 1 | 0 = latch off on overcurrent, 1 = sustain current limit |
| oc_flag | input | CHANNELS | Digitized overcurrent flag per channel |
| ot_flag | input | CHANNELS | Over-temperature flag per channel |
| vout_high | input | CHANNELS | Comparator result, output above diagnostic threshold |
| gate_en | output | CHANNELS | Gate enable per channel |
| status | output | CHANNELS | Diagnostic status bit per channel |

## Verification
Two events can coincide. A write strobe can arrive in the same cycle as an over-temperature trip, or as the blanking expiry of a held overcurrent. The bench lines up an over-temperature flag and a strobe on one negative edge. It then expects the channel to conduct in the next sample, because re-arming takes priority, and to be latched off one sample later. Blanking expiry is judged by counting the exact number of conducting samples after the strobe against `BLANK_CYCLES`+1 on every channel in turn.

// File: rtl/lsd_guard_pkg.sv
package lsd_guard_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_BLANK = 2'd1,
        CH_RUN   = 2'd2,
        CH_TRIP  = 2'd3
    } ch_state_t;

endpackage

// File: rtl/lsd_blank_timer.sv
module lsd_blank_timer #(
    parameter int BLANK_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(BLANK_CYCLES + 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (restart) begin
            remain_q <= CW'(BLANK_CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/lsd_channel_fsm.sv
module lsd_channel_fsm
    import lsd_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic cmd_on,
    input  logic limit_mode,
    input  logic oc,
    input  logic ot,
    input  logic blank_done,
    output logic gate_en,
    output logic latched
);
    ch_state_t state_q, state_d;
    logic      conducting;
    logic      short_hit;

    assign short_hit = oc && !limit_mode;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic; a write strobe overrides every other transition
    always_comb begin
        state_d = state_q;
        if (commit) begin
            state_d = cmd_on ? CH_BLANK : CH_IDLE;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (cmd_on) state_d = CH_BLANK;
                end
                CH_BLANK: begin
                    if (!cmd_on)         state_d = CH_IDLE;
                    else if (ot)         state_d = CH_TRIP;
                    else if (blank_done) state_d = short_hit ? CH_TRIP : CH_RUN;
                end
                CH_RUN: begin
                    if (!cmd_on)              state_d = CH_IDLE;
                    else if (ot || short_hit) state_d = CH_TRIP;
                end
                CH_TRIP: begin
                    state_d = CH_TRIP;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_BLANK, CH_RUN: begin
                conducting = 1'b1;
                latched    = 1'b0;
            end
            CH_TRIP: begin
                conducting = 1'b0;
                latched    = 1'b1;
            end
            CH_IDLE: begin
                conducting = 1'b0;
                latched    = 1'b0;
            end
        endcase
    end

    assign gate_en = conducting && cmd_on;

endmodule

// File: rtl/lsd_guard.sv
module lsd_guard #(
    parameter int CHANNELS     = 8,
    parameter int BLANK_CYCLES = 30000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [CHANNELS-1:0] cmd_on,
    input  logic                limit_mode,
    input  logic [CHANNELS-1:0] oc_flag,
    input  logic [CHANNELS-1:0] ot_flag,
    input  logic [CHANNELS-1:0] vout_high,
    output logic [CHANNELS-1:0] gate_en,
    output logic [CHANNELS-1:0] status
);
    logic                blank_done;
    logic [CHANNELS-1:0] latched;

    lsd_blank_timer #(
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (commit),
        .expired (blank_done)
    );

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        lsd_channel_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .commit     (commit),
            .cmd_on     (cmd_on[i]),
            .limit_mode (limit_mode),
            .oc         (oc_flag[i]),
            .ot         (ot_flag[i]),
            .blank_done (blank_done),
            .gate_en    (gate_en[i]),
            .latched    (latched[i])
        );
    end

    // a latched channel floats its drain high, so it always reports a fault
    assign status = vout_high | latched;

endmodule

// File: rtl/lsd_guard_chk.sv
module lsd_guard_chk #(
    parameter int CHANNELS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                commit,
    input logic [CHANNELS-1:0] cmd_on,
    input logic                limit_mode,
    input logic [CHANNELS-1:0] oc_flag,
    input logic [CHANNELS-1:0] ot_flag,
    input logic [CHANNELS-1:0] vout_high,
    input logic                blank_done,
    input logic [CHANNELS-1:0] gate_en,
    input logic [CHANNELS-1:0] status
);
    // R1
    reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> gate_en == '0);

    for (genvar i = 0; i < CHANNELS; i++) begin : g_chk
        // R5
        oc_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_en[i] && oc_flag[i] && !limit_mode && blank_done && !commit)
            |=> !gate_en[i]);
        // R6
        limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_en[i] && limit_mode && !ot_flag[i] && !commit)
            |=> (gate_en[i] || !cmd_on[i]));
        // R7
        ot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_en[i] && ot_flag[i] && !commit) |=> !gate_en[i]);
        // R8
        latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !vout_high[i] && !commit) |=> !gate_en[i]);
        // R9
        commit_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && cmd_on[i]) |=> (gate_en[i] || !cmd_on[i]));
        // R10
        status_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en[i] |-> (status[i] == vout_high[i]));
    end

endmodule

bind lsd_guard lsd_guard_chk #(
    .CHANNELS(CHANNELS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .cmd_on     (cmd_on),
    .limit_mode (limit_mode),
    .oc_flag    (oc_flag),
    .ot_flag    (ot_flag),
    .vout_high  (vout_high),
    .blank_done (blank_done),
    .gate_en    (gate_en),
    .status     (status)
);

// File: tb/lsd_guard_bench.sv
`timescale 1ns/1ps
module lsd_guard_bench;
    localparam int N = 8;
    localparam int B = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         commit;
    logic [N-1:0] cmd_on, oc_flag, ot_flag, vout_high;
    logic         limit_mode;
    logic [N-1:0] gate_en, status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lsd_guard #(.CHANNELS(N), .BLANK_CYCLES(B)) u_lsd_guard (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmd_on(cmd_on),
        .limit_mode(limit_mode), .oc_flag(oc_flag), .ot_flag(ot_flag),
        .vout_high(vout_high), .gate_en(gate_en), .status(status)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_commit(input logic [N-1:0] c);
        cmd_on = c;
        commit = 1'b1;
        step();
        commit = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; commit = 1'b0; cmd_on = '0; limit_mode = 1'b0;
        oc_flag = '0; ot_flag = '0; vout_high = 8'hA5;
        repeat (3) step();
        check("R1 reset gates", gate_en, 8'h00);
        check("R10 reset status", status, 8'hA5);
        rst_n = 1'b1;
        step();
        check("R1 after release", gate_en, 8'h00);

        // R10: all channels idle, sweep every comparator pattern
        for (int v = 0; v < 256; v++) begin
            vout_high = 8'(v);
            #1;
            check("R10 idle status", status, 8'(v));
        end
        vout_high = '0;

        // R2: command patterns
        foreach (cmd_on[k]) begin end
        for (int p = 0; p < 6; p++) begin
            logic [N-1:0] pat;
            pat = 8'((p * 8'h4B) ^ (p << 5));
            do_commit(pat);
            check("R2 commit", gate_en, pat);
            repeat (B + 2) step();
            check("R2 steady", gate_en, pat);
        end

        // R10: all channels conducting
        do_commit(8'hFF);
        for (int v = 0; v < 256; v += 17) begin
            vout_high = 8'(v);
            #1;
            check("R10 on status", status, 8'(v));
        end
        vout_high = '0;

        // R3 / R8 / R9: blanking length on each channel
        for (int c = 0; c < N; c++) begin
            int hi;
            oc_flag = 8'(1 << c);
            do_commit(8'hFF);
            hi = 0;
            while (gate_en[c] && hi < 4 * B) begin
                hi++;
                step();
            end
            checks++;
            if (hi != B + 1) begin
                errors++;
                $display("FAIL R3 blank length ch%0d: actual=%0d expected=%0d", c, hi, B + 1);
            end
            check("R3 other channels", gate_en, 8'hFF & ~8'(1 << c));
            check("R8 tripped status", status, 8'(1 << c));
            oc_flag = '0;
            repeat (3) step();
            check("R8 latch holds", gate_en, 8'hFF & ~8'(1 << c));
            do_commit(8'hFF);
            check("R9 rearm", gate_en, 8'hFF);
        end

        // R4: short overcurrent inside the blanking window
        do_commit(8'hFF);
        oc_flag = 8'h0F;
        repeat (B / 2) step();
        oc_flag = '0;
        repeat (B + 4) step();
        check("R4 blanked pulse", gate_en, 8'hFF);

        // R5: overcurrent after expiry trips at the next edge
        oc_flag = 8'h20;
        step();
        check("R5 immediate trip", gate_en, 8'hDF);
        oc_flag = '0;

        // R6 / R7 / R8 in current-limit mode
        limit_mode = 1'b1;
        do_commit(8'hFF);
        oc_flag = 8'hFF;
        repeat (3 * B) step();
        check("R6 limit hold", gate_en, 8'hFF);
        ot_flag = 8'h08;
        step();
        check("R7 thermal trip limit", gate_en, 8'hF7);
        ot_flag = '0; oc_flag = '0;
        step();
        check("R8 latch holds limit", gate_en, 8'hF7);
        limit_mode = 1'b0;

        // R7: over-temperature during blanking
        do_commit(8'hFF);
        ot_flag = 8'h40;
        step();
        check("R7 thermal trip blank", gate_en, 8'hBF);
        ot_flag = '0;

        // R9: commit with bit clear
        do_commit(8'h00);
        check("R9 commit off", gate_en, 8'h00);
        check("R9 status off", status, 8'h00);

        // R9: strobe and thermal trip in the same cycle
        do_commit(8'hFF);
        repeat (B + 2) step();
        ot_flag = 8'h04;
        cmd_on = 8'hFF;
        commit = 1'b1;
        step();
        commit = 1'b0;
        check("R9 strobe wins", gate_en, 8'hFF);
        step();
        check("R9 trip after strobe", gate_en, 8'hFB);
        ot_flag = '0;

        // R1: reset in operation
        do_commit(8'hFF);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", gate_en, 8'h00);
        cmd_on = '0;
        step();
        rst_n = 1'b1;
        step();
        check("R1 after reset", gate_en, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule